// File: doc/BRIEF.md
# Display Data Channel Read Engine

This block fetches sink identification and link-protection data over a two-wire display data channel. Software writes a command word that names a transaction type, a byte count and a start bit. The engine then issues a start condition and the device address with the read bit. It clocks in the data bytes, acknowledging each one except the last, and closes with a stop condition. Received bytes land in a 64-byte buffer that software reads as sixteen 32-bit words.

Transfers longer than 64 bytes arrive in chunks. When a chunk fills and more bytes are still due, the engine raises the full status and holds the clock low. It waits until software has cleared that status and set the continue bit, and only then resumes into a freshly zeroed buffer. Completion, full, bus error and a hot-plug edge each latch their own status bit. The interrupt line is the OR of the latched bits that are enabled.

The sequencer moves through these states. IDLE goes to START on a start request, or straight to FIN for a write-type or zero-length command. START goes to ADDR after the start condition. ADDR goes to AACK after eight address bits. AACK goes to RECV on an acknowledge and to STOP on a missing one. RECV goes to MACK after eight data bits. MACK goes to STOP after the last byte, to HOLD when a chunk is full, and otherwise back to RECV. HOLD goes to RECV once the resume conditions are met. STOP goes to FIN after the stop condition. FIN goes to IDLE once software clears the start bit.

Top module: `ddc_read_engine`

## Requirements
- R1: After reset the following hold. Interrupt enable and status read 0, the command word reads 0, the divider reads 4, `irq_o` is low, `scl_o` is high and `sda_oe_o` is low.
- R2: The command word sits at offset 0x240. Bit 0 is start, bit 1 is continue, bits [3:2] are the transaction type and bits [31:20] are the byte count. It reads back as written, and writing it with bit 0 clear starts nothing.
- R3: A read transaction begins with a start condition followed by the address byte, sent MSB first. For type 3 (identification read) the address byte is 0xA1. For types 1 and 2 (protection reads) it is 0x75.
- R4: The buffer occupies offsets 0x200 to 0x23C. Byte n of a chunk sits in word n/4 at bits [8*(n%4)+7 : 8*(n%4)]. Bytes of the last chunk beyond the count read as 0.
- R5: A chunk fills when its 64th byte arrives with more bytes still due. The engine then sets status bit 3 and holds SCL low. It resumes only after bit 3 has been cleared and the continue bit written, in either order.
- R6: After the last byte is answered with a NACK and the stop condition is sent, status bit 2 (done) is set. A final chunk raises no full status, even when it is exactly 64 bytes.
- R7: If the sink does not acknowledge the address byte, status bit 4 (error) and bit 2 are both set, and no data byte is clocked.
- R8: Type 0 (protection write) or a byte count of 0 sets done with no SCL activity.
- R9: Status sits at 0x254 and enable at 0x250. Status bits latch whether or not they are enabled, and writing 1 to a status bit clears it. `irq_o` is high exactly when some status bit and its enable bit are both set.
- R10: A rising edge on `hp_det_i` sets status bit 0.
- R11: After done the engine starts no new transfer while the start bit stays set. Clearing the start bit returns it to idle.
- R12: The divider register sits at 0x258. Each SCL half period lasts divider+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hp_det_i | input | 1 | Hot-plug detect level |
| sda_i | input | 1 | Sensed data line level |
| scl_o | output | 1 | Bus clock level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
Several faults show up at the ports within one bit period. A sequencer stuck in the wrong state makes SCL stop toggling or keep toggling during HOLD, and a wrong bit counter shifts the address byte the sink records. A wrong chunk index or a missed buffer clear appears on the very next buffer read after full or done, as a misplaced byte or a leftover nonzero byte. Broken status latching shows up on `irq_o` in the cycle after the event, and a missing return to idle shows up as a second done while start is still held.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_AACK, ST_RECV,
        ST_MACK, ST_HOLD, ST_STOP, ST_FIN
    } seq_state_t;

    localparam int unsigned CHUNK_BYTES = 64;
    localparam int unsigned IRQ_W       = 5;
    localparam int unsigned IRQ_HP      = 0;
    localparam int unsigned IRQ_DONE    = 2;
    localparam int unsigned IRQ_FULL    = 3;
    localparam int unsigned IRQ_ERR     = 4;

    localparam logic [11:0] OFS_BUF = 12'h200;
    localparam logic [11:0] OFS_CMD = 12'h240;
    localparam logic [11:0] OFS_IEN = 12'h250;
    localparam logic [11:0] OFS_IST = 12'h254;
    localparam logic [11:0] OFS_DIV = 12'h258;

    localparam logic [1:0] TT_PROT_WR  = 2'd0;
    localparam logic [1:0] TT_PROT_CHK = 2'd1;
    localparam logic [1:0] TT_PROT_RD  = 2'd2;
    localparam logic [1:0] TT_ID_RD    = 2'd3;
endpackage

// File: rtl/ddc_clkdiv.sv
module ddc_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt_q == div) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/ddc_rx_buffer.sv
module ddc_rx_buffer #(
    parameter int unsigned BYTES = 64,
    localparam int unsigned WORDS  = BYTES / 4,
    localparam int unsigned IDX_W  = $clog2(BYTES),
    localparam int unsigned WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [31:0]       rd_data
);
    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < int'(BYTES); i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_byte;
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) rd_data[8*b +: 8] = mem_q[{rd_word, 2'(b)}];
    end
endmodule

// File: rtl/ddc_irq_ctrl.sv
module ddc_irq_ctrl #(
    parameter int unsigned SRC_W = 5,
    parameter logic [SRC_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic             ist_we,
    input  logic [SRC_W-1:0] wdata,
    input  logic [SRC_W-1:0] events,
    output logic [SRC_W-1:0] ien,
    output logic [SRC_W-1:0] status,
    output logic             irq
);
    logic [SRC_W-1:0] w1c;

    assign w1c = ist_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien    <= '0;
            status <= '0;
        end else begin
            if (ien_we) ien <= wdata & VALID;
            status <= ((status & ~w1c) | events) & VALID;
        end
    end

    assign irq = |(status & ien);
endmodule

// File: rtl/ddc_seq.sv
module ddc_seq
    import ddc_pkg::*;
#(
    parameter int unsigned LEN_W = 12,
    parameter int unsigned IDX_W = 6,
    parameter logic [6:0]  ID_DEV   = 7'h50,
    parameter logic [6:0]  PROT_DEV = 7'h3A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_req,
    input  logic             cont_req,
    input  logic             full_pend,
    input  logic [1:0]       ttype,
    input  logic [LEN_W-1:0] len,
    input  logic             sda_i,
    output logic             busy,
    output logic             scl,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic             clr_buf,
    output logic             ev_done,
    output logic             ev_full,
    output logic             ev_err,
    output logic             cont_ack,
    output seq_state_t       st
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

    seq_state_t       st_n;
    logic             half_q;
    logic [2:0]       bitn_q;
    logic [7:0]       sh_q;
    logic [LEN_W-1:0] remain_q;
    logic [IDX_W-1:0] idx_q;
    logic             bit_end;

    assign bit_end = tick && half_q;

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (run_req)
                          st_n = (ttype == TT_PROT_WR || len == '0) ? ST_FIN : ST_START;
            ST_START: if (bit_end) st_n = ST_ADDR;
            ST_ADDR:  if (bit_end && bitn_q == 3'd0) st_n = ST_AACK;
            ST_AACK:  if (bit_end) st_n = sda_i ? ST_STOP : ST_RECV;
            ST_RECV:  if (bit_end && bitn_q == 3'd0) st_n = ST_MACK;
            ST_MACK:  if (bit_end)
                          st_n = (remain_q == '0) ? ST_STOP
                               : (idx_q == LAST_IDX) ? ST_HOLD : ST_RECV;
            ST_HOLD:  if (cont_req && !full_pend) st_n = ST_RECV;
            ST_STOP:  if (bit_end) st_n = ST_FIN;
            ST_FIN:   if (!run_req) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register and bit datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            half_q   <= 1'b0;
            bitn_q   <= 3'd7;
            sh_q     <= '0;
            remain_q <= '0;
            idx_q    <= '0;
        end else begin
            st <= st_n;
            if (st != st_n)  half_q <= 1'b0;
            else if (tick)   half_q <= ~half_q;
            if (st == ST_IDLE) begin
                bitn_q   <= 3'd7;
                sh_q     <= {(ttype == TT_ID_RD) ? ID_DEV : PROT_DEV, 1'b1};
                remain_q <= len;
                idx_q    <= '0;
            end else begin
                if (bit_end && (st == ST_ADDR || st == ST_RECV)) bitn_q <= bitn_q - 3'd1;
                if (bit_end && st == ST_ADDR) sh_q <= {sh_q[6:0], 1'b0};
                if (bit_end && st == ST_RECV) sh_q <= {sh_q[6:0], sda_i};
                if (wr_en) remain_q <= remain_q - 1'b1;
                if (bit_end && st == ST_MACK) idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        scl    = 1'b1;
        sda_oe = 1'b0;
        unique case (st)
            ST_IDLE, ST_FIN: ;
            ST_START:        sda_oe = half_q;
            ST_ADDR:         begin scl = half_q; sda_oe = ~sh_q[7]; end
            ST_AACK, ST_RECV: scl = half_q;
            ST_MACK:         begin scl = half_q; sda_oe = (remain_q != '0); end
            ST_HOLD:         scl = 1'b0;
            ST_STOP:         begin scl = half_q; sda_oe = 1'b1; end
            default:         ;
        endcase
        busy     = !(st inside {ST_IDLE, ST_HOLD, ST_FIN});
        wr_en    = (st == ST_RECV) && bit_end && (bitn_q == 3'd0);
        wr_idx   = idx_q;
        wr_byte  = {sh_q[6:0], sda_i};
        cont_ack = (st == ST_HOLD) && (st_n == ST_RECV);
        clr_buf  = cont_ack || (st == ST_IDLE && st_n == ST_START);
        ev_done  = (st_n == ST_FIN) && (st != ST_FIN);
        ev_full  = (st == ST_MACK) && (st_n == ST_HOLD);
        ev_err   = (st == ST_AACK) && (st_n == ST_STOP);
    end
endmodule

// File: rtl/ddc_read_engine.sv
module ddc_read_engine
    import ddc_pkg::*;
#(
    parameter int unsigned LEN_W    = 12,
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned DIV_RST  = 4,
    parameter logic [6:0]  ID_DEV   = 7'h50,
    parameter logic [6:0]  PROT_DEV = 7'h3A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hp_det_i,
    input  logic        sda_i,
    output logic        scl_o,
    output logic        sda_oe_o,
    output logic        irq_o
);
    localparam int unsigned WORDS   = CHUNK_BYTES / 4;
    localparam int unsigned IDX_W   = $clog2(CHUNK_BYTES);
    localparam int unsigned WSEL_W  = $clog2(WORDS);
    localparam int unsigned LEN_LSB = 20;
    localparam logic [IRQ_W-1:0] IRQ_VALID =
        IRQ_W'((1 << IRQ_HP) | (1 << IRQ_DONE) | (1 << IRQ_FULL) | (1 << IRQ_ERR));

    logic             cmd_en, cmd_cont;
    logic [1:0]       cmd_type;
    logic [LEN_W-1:0] cmd_len;
    logic [DIV_W-1:0] div_q;
    logic             hp_q;
    logic [IRQ_W-1:0] irq_en, irq_status, events;
    logic             tick, busy, wr_en, clr_buf, cont_ack;
    logic             ev_done, ev_full, ev_err;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_byte;
    logic [31:0]      buf_word;
    seq_state_t       seq_state;
    logic             in_buf;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign in_buf = (reg_addr >> (WSEL_W + 2)) == (OFS_BUF >> (WSEL_W + 2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_en   <= 1'b0;
            cmd_cont <= 1'b0;
            cmd_type <= '0;
            cmd_len  <= '0;
            div_q    <= DIV_W'(DIV_RST);
            hp_q     <= 1'b0;
        end else begin
            hp_q <= hp_det_i;
            if (reg_we && reg_addr == OFS_CMD) begin
                cmd_en   <= reg_wdata[0];
                cmd_cont <= reg_wdata[1];
                cmd_type <= reg_wdata[3:2];
                cmd_len  <= reg_wdata[LEN_LSB +: LEN_W];
            end else if (cont_ack) begin
                cmd_cont <= 1'b0;
            end
            if (reg_we && reg_addr == OFS_DIV) div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        events           = '0;
        events[IRQ_HP]   = hp_det_i && !hp_q;
        events[IRQ_DONE] = ev_done;
        events[IRQ_FULL] = ev_full;
        events[IRQ_ERR]  = ev_err;
    end

    always_comb begin
        reg_rdata = '0;
        if (in_buf) reg_rdata = buf_word;
        else unique case (reg_addr)
            OFS_CMD: begin
                reg_rdata[LEN_LSB +: LEN_W] = cmd_len;
                reg_rdata[3:0]              = {cmd_type, cmd_cont, cmd_en};
            end
            OFS_IEN: reg_rdata[IRQ_W-1:0] = irq_en;
            OFS_IST: reg_rdata[IRQ_W-1:0] = irq_status;
            OFS_DIV: reg_rdata[DIV_W-1:0] = div_q;
            default: reg_rdata = '0;
        endcase
    end

    ddc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
    );

    ddc_rx_buffer #(.BYTES(CHUNK_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr_buf), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_byte(wr_byte),
        .rd_word(reg_addr[2 +: WSEL_W]), .rd_data(buf_word)
    );

    ddc_irq_ctrl #(.SRC_W(IRQ_W), .VALID(IRQ_VALID)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ien_we(reg_we && reg_addr == OFS_IEN),
        .ist_we(reg_we && reg_addr == OFS_IST),
        .wdata(reg_wdata[IRQ_W-1:0]), .events(events),
        .ien(irq_en), .status(irq_status), .irq(irq_o)
    );

    ddc_seq #(.LEN_W(LEN_W), .IDX_W(IDX_W), .ID_DEV(ID_DEV), .PROT_DEV(PROT_DEV)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(cmd_en),
        .cont_req(cmd_cont), .full_pend(irq_status[IRQ_FULL]),
        .ttype(cmd_type), .len(cmd_len), .sda_i(sda_i),
        .busy(busy), .scl(scl_o), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .clr_buf(clr_buf),
        .ev_done(ev_done), .ev_full(ev_full), .ev_err(ev_err),
        .cont_ack(cont_ack), .st(seq_state)
    );
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker
    import ddc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl,
    input logic             tick,
    input logic             hp_det,
    input logic [IRQ_W-1:0] status,
    input logic             cmd_en,
    input logic             wr_en,
    input logic             ev_err,
    input seq_state_t       st
);
    // R5: no byte is stored while the full status is pending
    assert_no_fill_while_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[IRQ_FULL] |-> !wr_en);

    // R11: finished engine stays parked while start is held
    assert_park_until_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIN && cmd_en) |=> (st == ST_FIN));

    // R7: missing address acknowledge leads straight to the stop sequence
    assert_err_to_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (st == ST_STOP));

    // R12: SCL only moves on a divider tick
    assert_scl_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl) |-> $past(tick));

    // R10: a hot-plug rising edge is latched
    assert_hotplug_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_det) |=> status[IRQ_HP]);
endmodule

bind ddc_read_engine ddc_checker u_ddc_checker (
    .clk(clk), .rst_n(rst_n), .scl(scl_o), .tick(tick), .hp_det(hp_det_i),
    .status(irq_status), .cmd_en(cmd_en), .wr_en(wr_en), .ev_err(ev_err),
    .st(seq_state)
);

// File: tb/test_ddc_read_engine.sv
`timescale 1ns/1ps
module test_ddc_read_engine;
    typedef struct packed {
        logic [1:0]  tt;
        logic [11:0] len;
        logic        nack;
        logic [7:0]  div;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 12'd5,   1'b0, 8'd1},
        '{2'd3, 12'd64,  1'b0, 8'd0},
        '{2'd2, 12'd130, 1'b0, 8'd1},
        '{2'd1, 12'd3,   1'b1, 8'd2},
        '{2'd0, 12'd8,   1'b0, 8'd1},
        '{2'd3, 12'd0,   1'b0, 8'd1},
        '{2'd1, 12'd70,  1'b0, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hp_det = 1'b0;
    logic        scl, sda_oe, irq;
    logic        sink_low = 1'b0;
    wire         sda_line = ~(sda_oe | sink_low);

    int   n_chk = 0, n_fail = 0;
    int   rises = 0, scl_falls = 0, cur_len = 0, seed = 0;
    bit   nack_mode = 1'b0;
    logic [7:0] addr_seen = '0;

    always #2 clk = ~clk;

    ddc_read_engine i_ddc_read_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hp_det_i(hp_det),
        .sda_i(sda_line), .scl_o(scl), .sda_oe_o(sda_oe), .irq_o(irq)
    );

    function automatic logic [7:0] pat(int k, int s);
        return 8'(k * 37 + s * 11 + 5);
    endfunction

    // sink model
    always @(negedge sda_line) begin
        #1;
        if (scl) begin rises = 0; sink_low = 1'b0; addr_seen = '0; end
    end
    always @(posedge scl) begin
        if (rises < 8) addr_seen = {addr_seen[6:0], sda_line};
        rises++;
    end
    always @(negedge scl) begin
        int f, p;
        logic [7:0] bv;
        scl_falls++;
        f = rises / 9;
        p = rises % 9;
        bv = pat(f - 1, seed);
        if (f == 0)                                    sink_low = (p == 8) && !nack_mode;
        else if (!nack_mode && p < 8 && f - 1 < cur_len) sink_low = ~bv[7 - p];
        else                                           sink_low = 1'b0;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    task automatic chk_chunk(input int base, input int count, input string req);
        logic [31:0] d, e;
        for (int w = 0; w < 16; w++) begin
            rd(12'h200 + 12'(4 * w), d);
            for (int b = 0; b < 4; b++)
                e[8*b +: 8] = (4 * w + b < count) ? pat(base + 4 * w + b, seed) : 8'h00;
            check(d == e, req, d, e);
        end
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        logic [31:0] cmd, st, d;
        int chunk, falls0, exp_full;
        bit ok, done, rdx;
        v = VECS[vi];
        rdx = (v.tt != 2'd0) && (v.len != 0);
        exp_full = (rdx && !v.nack) ? (int'(v.len) - 1) / 64 : 0;
        cur_len = int'(v.len); nack_mode = v.nack; seed = vi;
        wr(12'h258, 32'(v.div));
        wr(12'h250, 32'h1C);
        cmd = (32'(v.len) << 20) | (32'(v.tt) << 2) | 32'h1;
        falls0 = scl_falls;
        wr(12'h240, cmd);
        chunk = 0; done = 1'b0;
        while (!done) begin
            wait_irq(ok);
            if (!ok) begin check(1'b0, "R6 watchdog", 0, 1); return; end
            rd(12'h254, st);
            if (st[3]) begin
                chk_chunk(chunk * 64, 64, "R4 full chunk");
                if (chunk == 0) begin
                    wr(12'h240, cmd | 32'h2);
                    repeat (40) @(negedge clk);
                    check(scl == 1'b0, "R5 stall until full cleared", 32'(scl), 0);
                    rd(12'h200, d);
                    check(d[7:0] == pat(0, seed), "R5 buffer held during stall", d, 32'(pat(0, seed)));
                    wr(12'h254, 32'h8);
                end else begin
                    wr(12'h254, 32'h8);
                    wr(12'h240, cmd | 32'h2);
                end
                chunk++;
            end else if (st[2]) begin
                done = 1'b1;
                check(st[4] == (rdx && v.nack), "R7 error status", st, 32'(rdx && v.nack));
                check(chunk == exp_full, "R6 full count", chunk, exp_full);
                if (rdx) begin
                    d = (v.tt == 2'd3) ? 32'hA1 : 32'h75;
                    check(addr_seen == d[7:0], "R3 address byte", addr_seen, d);
                end else begin
                    check(scl_falls == falls0 && scl, "R8 no bus activity", scl_falls - falls0, 0);
                end
                if (rdx && !v.nack) chk_chunk(chunk * 64, int'(v.len) - chunk * 64, "R4 last chunk");
                wr(12'h254, st);
                repeat (30) @(negedge clk);
                rd(12'h254, d);
                check(d == 0 && scl, "R11 no restart while start held", d, 0);
                wr(12'h240, 32'h0);
            end
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok;
        real t0, t1;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(12'h254, d); check(d == 0, "R1 status", d, 0);
        rd(12'h250, d); check(d == 0, "R1 enable", d, 0);
        rd(12'h240, d); check(d == 0, "R1 command", d, 0);
        rd(12'h258, d); check(d == 4, "R1 divider", d, 4);
        check(!irq && scl && !sda_oe, "R1 pins", {irq, scl, sda_oe}, 3'b010);

        // R2 command readback without start
        wr(12'h240, 32'hABC0_000E);
        rd(12'h240, d); check(d == 32'hABC0_000E, "R2 command readback", d, 32'hABC0_000E);
        repeat (10) @(negedge clk);
        check(scl && !sda_oe, "R2 no start without bit 0", scl, 1);
        wr(12'h240, 32'h0);

        // R10 / R9 hot-plug latch, masking, W1C
        @(negedge clk) hp_det = 1'b1;
        repeat (3) @(negedge clk);
        rd(12'h254, d); check(d == 32'h1, "R10 hot-plug latched", d, 1);
        check(!irq, "R9 masked source keeps irq low", irq, 0);
        wr(12'h250, 32'h1);
        @(negedge clk); check(irq, "R9 enabled source raises irq", irq, 1);
        wr(12'h254, 32'h1);
        rd(12'h254, d); check(d == 0 && !irq, "R9 write-one clears", d, 0);
        wr(12'h250, 32'h0);
        @(negedge clk) hp_det = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(i);

        // R12 SCL period with divider 2
        cur_len = 1; nack_mode = 1'b0; seed = 9;
        wr(12'h258, 32'd2);
        wr(12'h250, 32'h1C);
        wr(12'h240, (32'd1 << 20) | (32'd3 << 2) | 32'h1);
        @(negedge scl); @(posedge scl); t0 = $realtime;
        @(posedge scl); t1 = $realtime;
        check((t1 - t0) == 24.0, "R12 SCL period", 32'(int'(t1 - t0)), 24);
        wait_irq(ok);
        rd(12'h254, d); check(ok && d == 32'h4, "R6 single byte done", d, 4);
        rd(12'h200, d); check(d == 32'(pat(0, 9)), "R4 single byte placement", d, 32'(pat(0, 9)));
        wr(12'h254, 32'h1F);
        wr(12'h240, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule